// File: doc/BRIEF.md
# Return and Interrupt-Return Sequencer

This block is the part of a small CPU core that carries out two return-type instructions. One returns from an interrupt and the other returns with an 8-bit literal. Each instruction takes one word and runs for two instruction cycles. Every instruction cycle is split into four phases, Q1 to Q4, and the phase is supplied from outside the block.

The block holds three things:
- a hardware return-address stack, filled by call and interrupt-entry logic through a push port;
- a set of shadow copies of the working, status and bank-select registers;
- the two global interrupt enables, one for high priority and one for low priority.

On an interrupt return the block pops the stack into the program counter and sets one of the two enables. It can also reload the three core registers from their shadows. On a literal return it writes the literal into the working register and pops the stack into the program counter.

Interrupt entry pulses a capture strobe together with the return-address push. The strobe takes snapshots of the core registers and of the priority level of the interrupt being entered. The upper program-counter latches are outside the block, and neither instruction touches them.

Top module: `ret_seq`

## Requirements
- R1: After synchronous reset the following outputs are zero: program counter, working, status and bank registers, both interrupt enables, the overflow and underflow flags, busy and pc_load.
- R2: Literal return, opcode 0x0C00 plus k in bits 7:0. The block loads k into the working register and the popped stack top into pc_o on the third rising edge after the Q1 edge that accepted the opcode. pc_load_o is high for exactly one cycle. Status and bank registers are unchanged.
- R3: Interrupt return with bit 0 clear, opcode 0x0010. The block pops the stack into pc_o and sets one interrupt enable. Working, status and bank registers are left unchanged.
- R4: Interrupt return with bit 0 set, opcode 0x0011. Working, status and bank registers are loaded with the shadow values taken at the most recent capture strobe.
- R5: An interrupt return sets the high-priority enable when priority mode (prio_en_i) is off or the captured interrupt was high priority. Otherwise it sets the low-priority enable. A capture strobe clears the enable chosen by the same rule, using capture_hi_i. The other enable keeps its value.
- R6: An accepted instruction keeps busy_o high from the accepting Q1 edge through the seventh edge after it, which is two full cycles. A start presented while busy is ignored.
- R7: The stack is last-in first-out and holds 31 return addresses of 21 bits.
- R8: Popping an empty stack loads zero into pc_o and sets a sticky underflow flag.
- R9: Pushing onto a full stack sets a sticky overflow flag and leaves the stored entries unchanged.
- R10: A start is ignored when the phase is not Q1 (phase_i = 0) or the opcode is neither return. The block stays idle and its registers and stack are untouched.
- R11: When idle, reg_we_i loads the three core registers on the next edge. Shadow copies change only on a capture strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 2 | Current phase, 0..3 for Q1..Q4 |
| start_i | input | 1 | Instruction word valid, sampled at Q1 |
| instr_i | input | 16 | Instruction word |
| push_i | input | 1 | Push a return address (honoured when idle) |
| push_addr_i | input | 21 | Return address to push |
| capture_i | input | 1 | Interrupt-entry shadow capture strobe (honoured when idle) |
| capture_hi_i | input | 1 | Entered interrupt is high priority |
| prio_en_i | input | 1 | Two-level priority mode enabled |
| reg_we_i | input | 1 | Write core registers |
| reg_w_i | input | 8 | Working register write value |
| reg_status_i | input | 8 | Status register write value |
| reg_bsr_i | input | 8 | Bank-select register write value |
| pc_o | output | 21 | Program counter loaded by a return |
| pc_load_o | output | 1 | One-cycle strobe when pc_o is loaded |
| w_o | output | 8 | Working register |
| status_o | output | 8 | Status register |
| bsr_o | output | 8 | Bank-select register |
| gieh_o | output | 1 | High-priority global interrupt enable |
| giel_o | output | 1 | Low-priority global interrupt enable |
| busy_o | output | 1 | Return sequence in progress |
| stk_ovf_o | output | 1 | Sticky stack overflow flag |
| stk_unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The Q1 edge that accepts an instruction is counted as edge zero. The program counter, the working register, the restored registers and the interrupt enable all change on edge three. The load strobe drops on edge four, and busy falls after edge seven.

The bench finds the accepting edge by presenting the opcode only when the phase it drives is Q1. It then counts falling edges from that point. Outputs are sampled just after edges two, three, four, six and seven, so both the "not yet" and the "now" side of every result are checked.

Pushes, captures and register writes are one-cycle strobes. Their results are read after the single edge that follows them.

// File: rtl/ret_seq_pkg.sv
package ret_seq_pkg;

    localparam int PC_W      = 21;
    localparam int REG_W     = 8;
    localparam int INSTR_W   = 16;
    localparam int STK_DEPTH = 31;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RETI = 2'd1,
        OP_RETK = 2'd2
    } op_e;

    typedef struct packed {
        logic [REG_W-1:0] w;
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] bsr;
    } core_regs_t;

    typedef struct packed {
        op_e              op;
        logic             fast;
        logic [REG_W-1:0] lit;
    } dec_t;

    // Interrupt return: 0x0010 / 0x0011, literal return: 0x0Ckk
    function automatic dec_t decode_op(input logic [INSTR_W-1:0] iw);
        dec_t d;
        d.op   = OP_NONE;
        d.fast = 1'b0;
        d.lit  = '0;
        if (iw[15:1] == 15'h0008) begin
            d.op   = OP_RETI;
            d.fast = iw[0];
        end else if (iw[15:8] == 8'h0C) begin
            d.op  = OP_RETK;
            d.lit = iw[7:0];
        end
        return d;
    endfunction

endpackage

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int DEPTH = 31,
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] top_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    ptr;
    logic             empty;
    logic             full;
    logic             wr_en;
    logic [PW-1:0]    ptr_dec;

    assign empty   = (ptr == '0);
    assign full    = (ptr == PW'(DEPTH));
    assign wr_en   = push_i && !pop_i && !full;
    assign ptr_dec = ptr - PW'(1);
    assign top_o   = empty ? '0 : mem[AW'(ptr_dec)];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && (ptr == PW'(g))) begin
                mem[g] <= push_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else if (pop_i) begin
            if (empty) begin
                unf_o <= 1'b1;
            end else begin
                ptr <= ptr_dec;
            end
        end else if (push_i) begin
            if (full) begin
                ovf_o <= 1'b1;
            end else begin
                ptr <= ptr + PW'(1);
            end
        end
    end

endmodule

// File: rtl/ret_shadow.sv
module ret_shadow
    import ret_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture_i,
    input  core_regs_t live_i,
    input  logic       hi_i,
    output core_regs_t shadow_o,
    output logic       hi_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_o <= '0;
            hi_o     <= 1'b1;
        end else if (capture_i) begin
            shadow_o <= live_i;
            hi_o     <= hi_i;
        end
    end

endmodule

// File: rtl/ret_ctrl.sv
module ret_ctrl
    import ret_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         phase_i,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               busy_o,
    output logic               fire_o,
    output dec_t               dec_o
);
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CYC1  = 2'd1,
        S_CYC2  = 2'd2
    } state_e;

    state_e state;
    dec_t   dec_in;
    logic   accept;
    logic   at_q4;

    assign dec_in = decode_op(instr_i);
    assign accept = (state == S_IDLE) && start_i &&
                    (phase_i == PH_Q1) && (dec_in.op != OP_NONE);
    assign at_q4  = (phase_i == PH_Q4);
    assign busy_o = (state != S_IDLE);
    assign fire_o = (state == S_CYC1) && at_q4;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            dec_o <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    state <= S_CYC1;
                    dec_o <= dec_in;
                end
                S_CYC1: if (at_q4) state <= S_CYC2;
                S_CYC2: if (at_q4) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ret_seq.sv
module ret_seq
    import ret_seq_pkg::*;
#(
    parameter int ADDR_W = PC_W,
    parameter int DEPTH  = STK_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         phase_i,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               push_i,
    input  logic [ADDR_W-1:0]  push_addr_i,
    input  logic               capture_i,
    input  logic               capture_hi_i,
    input  logic               prio_en_i,
    input  logic               reg_we_i,
    input  logic [REG_W-1:0]   reg_w_i,
    input  logic [REG_W-1:0]   reg_status_i,
    input  logic [REG_W-1:0]   reg_bsr_i,
    output logic [ADDR_W-1:0]  pc_o,
    output logic               pc_load_o,
    output logic [REG_W-1:0]   w_o,
    output logic [REG_W-1:0]   status_o,
    output logic [REG_W-1:0]   bsr_o,
    output logic               gieh_o,
    output logic               giel_o,
    output logic               busy_o,
    output logic               stk_ovf_o,
    output logic               stk_unf_o
);
    core_regs_t          regs_q;
    core_regs_t          shadow;
    core_regs_t          reg_in;
    logic                shadow_hi;
    logic                fire;
    dec_t                dec;
    logic [ADDR_W-1:0]   stk_top;
    logic                push_ok;
    logic                cap_ok;
    logic                reti_fire;

    assign push_ok   = push_i && !busy_o;
    assign cap_ok    = capture_i && !busy_o;
    assign reti_fire = fire && (dec.op == OP_RETI);
    assign reg_in    = '{w: reg_w_i, status: reg_status_i, bsr: reg_bsr_i};

    ret_ctrl i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_i),
        .start_i (start_i),
        .instr_i (instr_i),
        .busy_o  (busy_o),
        .fire_o  (fire),
        .dec_o   (dec)
    );

    ret_stack #(.DEPTH(DEPTH), .WIDTH(ADDR_W)) i_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push_ok),
        .push_data_i (push_addr_i),
        .pop_i       (fire),
        .top_o       (stk_top),
        .ovf_o       (stk_ovf_o),
        .unf_o       (stk_unf_o)
    );

    ret_shadow i_shadow (
        .clk       (clk),
        .rst       (rst),
        .capture_i (cap_ok),
        .live_i    (regs_q),
        .hi_i      (capture_hi_i),
        .shadow_o  (shadow),
        .hi_o      (shadow_hi)
    );

    // Program counter and core registers; the sequencer wins over writes
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_o      <= '0;
            pc_load_o <= 1'b0;
            regs_q    <= '0;
        end else begin
            pc_load_o <= fire;
            if (fire) begin
                pc_o <= stk_top;
                if (dec.op == OP_RETK) begin
                    regs_q.w <= dec.lit;
                end else if (dec.fast) begin
                    regs_q <= shadow;
                end
            end else if (reg_we_i) begin
                regs_q <= reg_in;
            end
        end
    end

    // Global interrupt enables
    always_ff @(posedge clk) begin
        if (rst) begin
            gieh_o <= 1'b0;
            giel_o <= 1'b0;
        end else if (reti_fire) begin
            if (!prio_en_i || shadow_hi) gieh_o <= 1'b1;
            else                         giel_o <= 1'b1;
        end else if (cap_ok) begin
            if (!prio_en_i || capture_hi_i) gieh_o <= 1'b0;
            else                            giel_o <= 1'b0;
        end
    end

    assign w_o      = regs_q.w;
    assign status_o = regs_q.status;
    assign bsr_o    = regs_q.bsr;

endmodule

// File: rtl/ret_seq_chk.sv
module ret_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase_i,
    input logic       start_i,
    input logic       capture_i,
    input logic       reg_we_i,
    input logic       pc_load_o,
    input logic       busy_o,
    input logic [7:0] status_o,
    input logic       gieh_o,
    input logic       stk_ovf_o,
    input logic       stk_unf_o
);
    a_r2_load_one_cycle: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !pc_load_o);

    a_r6_load_while_busy: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |-> busy_o);

    a_r10_idle_no_start: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> !busy_o);

    a_r10_idle_off_q1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (phase_i != 2'd0)) |=> !busy_o);

    a_r8_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        stk_unf_o |=> stk_unf_o);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        stk_ovf_o |=> stk_ovf_o);

    a_r11_status_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !reg_we_i) |=> $stable(status_o));

    a_r5_gieh_kept: assert property (@(posedge clk) disable iff (rst)
        (gieh_o && !capture_i) |=> gieh_o);

endmodule

bind ret_seq ret_seq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .phase_i   (phase_i),
    .start_i   (start_i),
    .capture_i (capture_i),
    .reg_we_i  (reg_we_i),
    .pc_load_o (pc_load_o),
    .busy_o    (busy_o),
    .status_o  (status_o),
    .gieh_o    (gieh_o),
    .stk_ovf_o (stk_ovf_o),
    .stk_unf_o (stk_unf_o)
);

// File: tb/test_ret_seq.sv
`timescale 1ns/1ps
module test_ret_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  phase = 2'd0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        push = 1'b0;
    logic [20:0] push_addr = '0;
    logic        capture = 1'b0;
    logic        capture_hi = 1'b0;
    logic        prio_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_w = '0, reg_status = '0, reg_bsr = '0;
    logic [20:0] pc;
    logic        pc_load, busy, gieh, giel, ovf, unf;
    logic [7:0]  w, status, bsr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ret_seq i_ret_seq (
        .clk(clk), .rst(rst), .phase_i(phase), .start_i(start), .instr_i(instr),
        .push_i(push), .push_addr_i(push_addr), .capture_i(capture),
        .capture_hi_i(capture_hi), .prio_en_i(prio_en), .reg_we_i(reg_we),
        .reg_w_i(reg_w), .reg_status_i(reg_status), .reg_bsr_i(reg_bsr),
        .pc_o(pc), .pc_load_o(pc_load), .w_o(w), .status_o(status), .bsr_o(bsr),
        .gieh_o(gieh), .giel_o(giel), .busy_o(busy),
        .stk_ovf_o(ovf), .stk_unf_o(unf)
    );

    // phase counter, driven on falling edges
    initial forever begin
        @(negedge clk);
        phase <= rst ? 2'd0 : phase + 2'd1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr_regs(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        reg_we = 1'b1; reg_w = a; reg_status = b; reg_bsr = c;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic do_push(input logic [20:0] a, input bit cap, input bit hi);
        push = 1'b1; push_addr = a; capture = cap; capture_hi = hi;
        step(1);
        push = 1'b0; capture = 1'b0;
    endtask

    // present an opcode so that it is sampled at a Q1 edge (edge zero)
    task automatic issue(input logic [15:0] iw);
        do step(1); while (phase != 2'd0);
        start = 1'b1; instr = iw;
        step(1);
        start = 1'b0; instr = '0;
    endtask

    task automatic retk_pop(input logic [7:0] k, input logic [20:0] exp_pc, input string req);
        issue({8'h0C, k});
        step(3);
        chk({req, " pc"}, 32'(pc), 32'(exp_pc));
        chk("R2 literal to w", 32'(w), 32'(k));
        step(4);
    endtask

    task automatic t_reset();
        chk("R1 pc", 32'(pc), 0);
        chk("R1 regs", {8'h0, w, status, bsr}, 0);
        chk("R1 flags", {26'h0, pc_load, busy, gieh, giel, ovf, unf}, 0);
    endtask

    task automatic t_regwrite();
        wr_regs(8'h11, 8'h22, 8'h33);
        chk("R11 write", {8'h0, w, status, bsr}, 32'h112233);
    endtask

    task automatic t_retlw();
        do_push(21'h12345, 1'b0, 1'b0);
        issue(16'h0CA5);
        step(2);
        chk("R6 busy edge2", 32'(busy), 1);
        chk("R2 no load edge2", 32'(pc_load), 0);
        step(1);
        chk("R2 pc", 32'(pc), 32'h12345);
        chk("R2 load strobe", 32'(pc_load), 1);
        chk("R2 w", 32'(w), 32'hA5);
        chk("R2 status bsr kept", {status, bsr}, 32'h2233);
        step(1);
        chk("R2 strobe drops", 32'(pc_load), 0);
        step(2);
        chk("R6 busy edge6", 32'(busy), 1);
        step(1);
        chk("R6 idle edge7", 32'(busy), 0);
    endtask

    task automatic t_busy_ignore();
        do_push(21'h00100, 1'b0, 1'b0);
        do_push(21'h00200, 1'b0, 1'b0);
        issue(16'h0C01);
        step(3);
        chk("R6 phase Q1 at edge4", 32'(phase), 0);
        start = 1'b1; instr = 16'h0C02;
        step(1);
        start = 1'b0; instr = '0;
        step(3);
        chk("R6 busy start ignored w", 32'(w), 32'h01);
        chk("R7 lifo first", 32'(pc), 32'h200);
        chk("R6 idle", 32'(busy), 0);
        retk_pop(8'h03, 21'h00100, "R7 lifo second");
    endtask

    task automatic t_invalid();
        issue(16'h0012);
        chk("R10 bad op idle", 32'(busy), 0);
        step(7);
        chk("R10 bad op pc", 32'(pc), 32'h100);
        chk("R10 bad op w", 32'(w), 32'h03);
        do step(1); while (phase != 2'd1);
        start = 1'b1; instr = 16'h0C09;
        step(1);
        start = 1'b0; instr = '0;
        chk("R10 off-Q1 idle", 32'(busy), 0);
        step(8);
        chk("R10 off-Q1 w", 32'(w), 32'h03);
    endtask

    task automatic t_reti_plain();
        prio_en = 1'b0;
        wr_regs(8'h44, 8'h45, 8'h46);
        do_push(21'h0AAAA, 1'b1, 1'b0);
        wr_regs(8'h55, 8'h66, 8'h77);
        issue(16'h0010);
        step(3);
        chk("R3 pc", 32'(pc), 32'h0AAAA);
        chk("R3 regs kept", {8'h0, w, status, bsr}, 32'h556677);
        chk("R5 prio off sets high", {gieh, giel}, 32'b10);
        step(4);
    endtask

    task automatic t_reti_fast();
        prio_en = 1'b1;
        wr_regs(8'h81, 8'h82, 8'h83);
        do_push(21'h1F0F0, 1'b1, 1'b0);
        chk("R5 low capture keeps high", {gieh, giel}, 32'b10);
        wr_regs(8'h90, 8'h91, 8'h92);
        chk("R11 shadow not written", 32'(w), 32'h90);
        issue(16'h0011);
        step(3);
        chk("R4 pc", 32'(pc), 32'h1F0F0);
        chk("R4 restore", {8'h0, w, status, bsr}, 32'h818283);
        chk("R5 low prio sets low", {gieh, giel}, 32'b11);
        step(4);
        wr_regs(8'hA1, 8'hA2, 8'hA3);
        do_push(21'h00ABC, 1'b1, 1'b1);
        chk("R5 high capture clears high", {gieh, giel}, 32'b01);
        wr_regs(8'hB1, 8'hB2, 8'hB3);
        issue(16'h0011);
        step(3);
        chk("R4 second restore", {8'h0, w, status, bsr}, 32'hA1A2A3);
        chk("R5 high prio sets high", {gieh, giel}, 32'b11);
        chk("R3 pc second", 32'(pc), 32'h00ABC);
        step(4);
    endtask

    task automatic t_underflow();
        chk("R8 no underflow yet", 32'(unf), 0);
        retk_pop(8'h7E, 21'h0, "R8 empty pop");
        chk("R8 underflow flag", 32'(unf), 1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 31; i++) do_push(21'(32'h100 + i), 1'b0, 1'b0);
        chk("R9 not full yet", 32'(ovf), 0);
        do_push(21'h1FFFF, 1'b0, 1'b0);
        chk("R9 overflow flag", 32'(ovf), 1);
        for (int i = 30; i >= 0; i--) retk_pop(8'(i), 21'(32'h100 + i), "R7 R9 order");
        chk("R9 sticky", 32'(ovf), 1);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_regwrite();
        t_retlw();
        t_busy_ignore();
        t_invalid();
        t_reti_plain();
        t_reti_fast();
        t_underflow();
        t_overflow();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule